// File: doc/BRIEF.md
# ADC Conversion Event Interrupt Unit

This block sits between an ADC conversion sequencer and an interrupt controller. The sequencer sends single-cycle strobes when a normal conversion ends, when a normal chain ends, when an injected conversion ends and when an injected chain ends. With each conversion strobe it also sends the number of the channel that was just converted. The unit records these events in sticky flags, applies the masks set by software, and drives one combined interrupt request.

Two groups of state are kept. A per-channel pending register has one bit for each channel, and a per-channel mask selects which of those bits may raise the interrupt. A four-bit event flag register has one bit for each event type, and a matching event mask enables each type. Software reads the flags through a small register port and clears them by writing ones. When a chain ends, the sequencer is expected to raise the end-of-chain strobe in the same cycle as the conversion strobe for the chain's last channel. Both flags are then set together.

Top module: `adc_evt_irq`

## Requirements
- R1: After a synchronous reset, the pending bits, event flags, both masks, `irq_o` and `rd_data_o` are all zero.
- R2: A normal or injected conversion strobe with channel number c below NUM_CH sets bit c of the pending register (address 0).
- R3: A conversion strobe whose channel number is NUM_CH or above changes no pending bit.
- R4: The event flag register (address 2) is set by the strobes, with bit 0 for normal conversion end, bit 1 for normal chain end, bit 2 for injected conversion end and bit 3 for injected chain end. A chain strobe that arrives with a conversion strobe sets both flags in the same cycle.
- R5: A write to address 0 or 2 clears each flag whose data bit is 1 and leaves the flags whose data bit is 0 unchanged.
- R6: When a flag is set by an event and cleared by a write in the same cycle, it ends up set.
- R7: `irq_o` is a register. At every clock edge it takes the OR of (pending AND channel mask) and (event flags AND event mask), computed on the values that edge writes.
- R8: The channel mask (address 1, bits NUM_CH-1:0) and the event mask (address 3, bits 3:0) can be read and written. The masks gate only `irq_o`: masked events are still recorded.
- R9: `rd_data_o` is registered. One cycle after `addr_i` is presented, it shows the value the selected register had before that clock edge. Bits above the register's width read as zero.
- R10: A write to a mask register does not change any pending bit or event flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_conv_i | input | 1 | Normal conversion finished |
| evt_chain_i | input | 1 | Normal chain finished |
| evt_iconv_i | input | 1 | Injected conversion finished |
| evt_ichain_i | input | 1 | Injected chain finished |
| conv_ch_i | input | CH_W | Channel number of the finished conversion |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register select (0 pending, 1 channel mask, 2 event flags, 3 event mask) |
| wdata_i | input | DATA_W | Write data |
| rd_data_o | output | DATA_W | Registered read data |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Every stored bit of this block can reach the ports. A corrupted pending bit, event flag or mask shows on `irq_o` at the next clock edge once the matching mask is set. It also shows on `rd_data_o` one cycle after its address is selected. The bench therefore compares both outputs against a behavioural model on every cycle. Any divergence in set, clear, priority or masking is caught within one or two cycles of the stimulus that causes it. Directed sequences add masked recording, out-of-range channels, and set/clear collisions on both flag groups.

// File: rtl/adc_evt_irq_pkg.sv
package adc_evt_irq_pkg;

  localparam int EV_NUM = 4;

  // Bit positions inside the event flag and event mask registers
  localparam int EV_CONV   = 0;
  localparam int EV_CHAIN  = 1;
  localparam int EV_ICONV  = 2;
  localparam int EV_ICHAIN = 3;

  typedef enum logic [1:0] {
    SEL_PEND  = 2'd0,
    SEL_CMASK = 2'd1,
    SEL_EFLAG = 2'd2,
    SEL_EMASK = 2'd3
  } reg_sel_e;

endpackage

// File: rtl/adc_evt_sticky.sv
// Bank of sticky flags: set by events, cleared by write-one, set has priority.
module adc_evt_sticky #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] flag_o,
  output logic [W-1:0] flag_nxt_o
);

  logic [W-1:0] flag_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign flag_nxt_o[i] = set_i[i] | (flag_q[i] & ~clr_i[i]);

    always_ff @(posedge clk) begin
      if (rst) flag_q[i] <= 1'b0;
      else     flag_q[i] <= flag_nxt_o[i];
    end
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/adc_evt_chan_dec.sv
// Turns a conversion strobe plus channel number into a one-hot set vector.
module adc_evt_chan_dec #(
  parameter int NUM_CH = 7,
  parameter int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              valid_i,
  input  logic [CH_W-1:0]   ch_i,
  output logic [NUM_CH-1:0] hit_o
);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign hit_o[c] = valid_i && (ch_i == CH_W'(c));
  end

endmodule

// File: rtl/adc_evt_regs.sv
// Mask registers, write decode for clears, registered read mux.
module adc_evt_regs
  import adc_evt_irq_pkg::*;
#(
  parameter int NUM_CH = 7,
  parameter int DATA_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [NUM_CH-1:0] pend_i,
  input  logic [EV_NUM-1:0] eflag_i,
  output logic [NUM_CH-1:0] pend_clr_o,
  output logic [EV_NUM-1:0] eflag_clr_o,
  output logic [NUM_CH-1:0] cmask_o,
  output logic [NUM_CH-1:0] cmask_nxt_o,
  output logic [EV_NUM-1:0] emask_o,
  output logic [EV_NUM-1:0] emask_nxt_o,
  output logic [DATA_W-1:0] rd_data_o
);

  reg_sel_e          sel;
  logic [NUM_CH-1:0] cmask_q;
  logic [EV_NUM-1:0] emask_q;
  logic [DATA_W-1:0] rd_q;
  logic [DATA_W-1:0] rd_nxt;

  assign sel = reg_sel_e'(addr_i);

  always_comb begin
    pend_clr_o  = '0;
    eflag_clr_o = '0;
    cmask_nxt_o = cmask_q;
    emask_nxt_o = emask_q;
    if (wr_en_i) begin
      unique case (sel)
        SEL_PEND:  pend_clr_o  = wdata_i[NUM_CH-1:0];
        SEL_CMASK: cmask_nxt_o = wdata_i[NUM_CH-1:0];
        SEL_EFLAG: eflag_clr_o = wdata_i[EV_NUM-1:0];
        SEL_EMASK: emask_nxt_o = wdata_i[EV_NUM-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_nxt = '0;
    unique case (sel)
      SEL_PEND:  rd_nxt[NUM_CH-1:0] = pend_i;
      SEL_CMASK: rd_nxt[NUM_CH-1:0] = cmask_q;
      SEL_EFLAG: rd_nxt[EV_NUM-1:0] = eflag_i;
      SEL_EMASK: rd_nxt[EV_NUM-1:0] = emask_q;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmask_q <= '0;
      emask_q <= '0;
      rd_q    <= '0;
    end else begin
      cmask_q <= cmask_nxt_o;
      emask_q <= emask_nxt_o;
      rd_q    <= rd_nxt;
    end
  end

  assign cmask_o   = cmask_q;
  assign emask_o   = emask_q;
  assign rd_data_o = rd_q;

endmodule

// File: rtl/adc_evt_irq.sv
module adc_evt_irq
  import adc_evt_irq_pkg::*;
#(
  parameter int NUM_CH = 7,
  parameter int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  parameter int DATA_W = (NUM_CH > EV_NUM) ? NUM_CH : EV_NUM
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              evt_conv_i,
  input  logic              evt_chain_i,
  input  logic              evt_iconv_i,
  input  logic              evt_ichain_i,
  input  logic [CH_W-1:0]   conv_ch_i,
  input  logic              wr_en_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              irq_o
);

  logic [NUM_CH-1:0] ch_hit;
  logic [NUM_CH-1:0] pend_q, pend_nxt, pend_clr;
  logic [EV_NUM-1:0] ev_set;
  logic [EV_NUM-1:0] eflag_q, eflag_nxt, eflag_clr;
  logic [NUM_CH-1:0] cmask_q, cmask_nxt;
  logic [EV_NUM-1:0] emask_q, emask_nxt;
  logic              irq_q;

  adc_evt_chan_dec #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_dec (
    .valid_i (evt_conv_i | evt_iconv_i),
    .ch_i    (conv_ch_i),
    .hit_o   (ch_hit)
  );

  adc_evt_sticky #(.W(NUM_CH)) u_pend (
    .clk        (clk),
    .rst        (rst),
    .set_i      (ch_hit),
    .clr_i      (pend_clr),
    .flag_o     (pend_q),
    .flag_nxt_o (pend_nxt)
  );

  always_comb begin
    ev_set            = '0;
    ev_set[EV_CONV]   = evt_conv_i;
    ev_set[EV_CHAIN]  = evt_chain_i;
    ev_set[EV_ICONV]  = evt_iconv_i;
    ev_set[EV_ICHAIN] = evt_ichain_i;
  end

  adc_evt_sticky #(.W(EV_NUM)) u_eflag (
    .clk        (clk),
    .rst        (rst),
    .set_i      (ev_set),
    .clr_i      (eflag_clr),
    .flag_o     (eflag_q),
    .flag_nxt_o (eflag_nxt)
  );

  adc_evt_regs #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_regs (
    .clk         (clk),
    .rst         (rst),
    .wr_en_i     (wr_en_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .pend_i      (pend_q),
    .eflag_i     (eflag_q),
    .pend_clr_o  (pend_clr),
    .eflag_clr_o (eflag_clr),
    .cmask_o     (cmask_q),
    .cmask_nxt_o (cmask_nxt),
    .emask_o     (emask_q),
    .emask_nxt_o (emask_nxt),
    .rd_data_o   (rd_data_o)
  );

  // Registered request built from the values being written this edge
  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= (|(pend_nxt & cmask_nxt)) | (|(eflag_nxt & emask_nxt));
  end

  assign irq_o = irq_q;

endmodule

// File: rtl/adc_evt_irq_chk.sv
module adc_evt_irq_chk #(
  parameter int NUM_CH = 7,
  parameter int CH_W   = 3,
  parameter int DATA_W = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              evt_conv_i,
  input logic              evt_chain_i,
  input logic              evt_iconv_i,
  input logic              evt_ichain_i,
  input logic [CH_W-1:0]   conv_ch_i,
  input logic              wr_en_i,
  input logic [1:0]        addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              irq_o,
  input logic [NUM_CH-1:0] pend,
  input logic [NUM_CH-1:0] cmask,
  input logic [3:0]        eflag,
  input logic [3:0]        emask
);

  assert_pend_set_R2: assert property (@(posedge clk) disable iff (rst)
    ((evt_conv_i || evt_iconv_i) && (int'(conv_ch_i) < NUM_CH)) |=> pend[$past(conv_ch_i)]);

  assert_no_spurious_pend_R3: assert property (@(posedge clk) disable iff (rst)
    !(evt_conv_i || evt_iconv_i) |=> ($countones(pend) <= $countones($past(pend))));

  assert_chain_flag_R4: assert property (@(posedge clk) disable iff (rst)
    evt_chain_i |=> eflag[1]);

  assert_set_wins_R6: assert property (@(posedge clk) disable iff (rst)
    (evt_ichain_i && wr_en_i && addr_i == 2'd2 && wdata_i[3]) |=> eflag[3]);

  assert_irq_combine_R7: assert property (@(posedge clk) disable iff (rst)
    irq_o == ((|(pend & cmask)) || (|(eflag & emask))));

  assert_read_cmask_R9: assert property (@(posedge clk) disable iff (rst)
    (addr_i == 2'd1) |=> (rd_data_o[NUM_CH-1:0] == $past(cmask)));

  assert_mask_write_keeps_flags_R10: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && addr_i == 2'd3 && !evt_conv_i && !evt_chain_i && !evt_iconv_i && !evt_ichain_i)
      |=> $stable(eflag));

endmodule

bind adc_evt_irq adc_evt_irq_chk #(.NUM_CH(NUM_CH), .CH_W(CH_W), .DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .evt_conv_i   (evt_conv_i),
  .evt_chain_i  (evt_chain_i),
  .evt_iconv_i  (evt_iconv_i),
  .evt_ichain_i (evt_ichain_i),
  .conv_ch_i    (conv_ch_i),
  .wr_en_i      (wr_en_i),
  .addr_i       (addr_i),
  .wdata_i      (wdata_i),
  .rd_data_o    (rd_data_o),
  .irq_o        (irq_o),
  .pend         (pend_q),
  .cmask        (cmask_q),
  .eflag        (eflag_q),
  .emask        (emask_q)
);

// File: tb/test_adc_evt_irq.sv
module test_adc_evt_irq;

  localparam int CLK_PERIOD = 10;
  localparam int NCH = 7;
  localparam int CHW = 3;
  localparam int DW  = 7;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          evt_conv = 1'b0, evt_chain = 1'b0, evt_iconv = 1'b0, evt_ichain = 1'b0;
  logic [CHW-1:0] conv_ch = '0;
  logic          wr_en = 1'b0;
  logic [1:0]    addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rd_data;
  logic          irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit model_on = 1'b0;

  // Reference state
  bit [NCH-1:0] m_pend, m_cmask;
  bit [3:0]     m_flag, m_emask;
  bit [DW-1:0]  m_rd;
  bit           m_irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_evt_irq #(.NUM_CH(NCH)) i_adc_evt_irq (
    .clk          (clk),
    .rst          (rst),
    .evt_conv_i   (evt_conv),
    .evt_chain_i  (evt_chain),
    .evt_iconv_i  (evt_iconv),
    .evt_ichain_i (evt_ichain),
    .conv_ch_i    (conv_ch),
    .wr_en_i      (wr_en),
    .addr_i       (addr),
    .wdata_i      (wdata),
    .rd_data_o    (rd_data),
    .irq_o        (irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural model, updated on each rising edge from the bench's own inputs
  always @(posedge clk) begin
    if (rst) begin
      m_pend = '0; m_cmask = '0; m_flag = '0; m_emask = '0; m_rd = '0; m_irq = 1'b0;
    end else begin
      case (addr)
        2'd0: m_rd = DW'(m_pend);
        2'd1: m_rd = DW'(m_cmask);
        2'd2: m_rd = DW'(m_flag);
        default: m_rd = DW'(m_emask);
      endcase
      if (wr_en) begin
        case (addr)
          2'd0: m_pend  = m_pend & ~wdata[NCH-1:0];
          2'd1: m_cmask = wdata[NCH-1:0];
          2'd2: m_flag  = m_flag & ~wdata[3:0];
          default: m_emask = wdata[3:0];
        endcase
      end
      if ((evt_conv || evt_iconv) && int'(conv_ch) < NCH) m_pend[conv_ch] = 1'b1;
      m_flag = m_flag | {evt_ichain, evt_iconv, evt_chain, evt_conv};
      m_irq = ((m_pend & m_cmask) != 0) || ((m_flag & m_emask) != 0);
    end
  end

  // Cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (model_on) begin
      check("R7 irq vs model", 32'(irq), 32'(m_irq));
      check("R9 rd_data vs model", 32'(rd_data), 32'(m_rd));
    end
  end

  task automatic cyc();
    @(posedge clk);
    #1;
    evt_conv = 0; evt_chain = 0; evt_iconv = 0; evt_ichain = 0;
    wr_en = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    wr_en = 1; addr = a; wdata = d;
    cyc();
  endtask

  task automatic rd(input logic [1:0] a, output logic [DW-1:0] v);
    addr = a;
    @(posedge clk);
    #1;
    v = rd_data;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [DW-1:0] v;
    rst = 1;
    repeat (3) @(posedge clk);
    #1;
    rst = 0;
    model_on = 1;
    check("R1 irq after reset", 32'(irq), 0);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      check("R1 register after reset", 32'(v), 0);
    end

    // Masked recording: normal conversion ch2 ending a chain
    evt_conv = 1; evt_chain = 1; conv_ch = 3'd2;
    cyc();
    check("R8 irq stays low while masked", 32'(irq), 0);
    rd(2'd2, v); check("R4 conv+chain flags", 32'(v), 32'h3);
    rd(2'd0, v); check("R2 pending ch2", 32'(v), 32'h04);

    // Injected conversion on ch6 ending an injected chain
    evt_iconv = 1; evt_ichain = 1; conv_ch = 3'd6;
    cyc();
    rd(2'd0, v); check("R2 injected sets pending ch6", 32'(v), 32'h44);
    rd(2'd2, v); check("R4 all four flags", 32'(v), 32'hF);

    // Out-of-range channel number
    evt_conv = 1; conv_ch = 3'd7;
    cyc();
    rd(2'd0, v); check("R3 channel 7 ignored", 32'(v), 32'h44);

    // Channel mask enables the interrupt
    wr(2'd1, 7'h04);
    check("R7 irq from masked pending", 32'(irq), 1);
    rd(2'd1, v); check("R8 channel mask readback", 32'(v), 32'h04);

    // Write-one clear of ch2
    wr(2'd0, 7'h04);
    check("R7 irq drops after clear", 32'(irq), 0);
    rd(2'd0, v); check("R5 pending after clear", 32'(v), 32'h40);

    // Event mask and set-wins on the chain flag
    wr(2'd3, 7'h02);
    check("R7 irq from chain flag", 32'(irq), 1);
    rd(2'd2, v); check("R10 flags unchanged by mask write", 32'(v), 32'hF);
    evt_chain = 1; wr_en = 1; addr = 2'd2; wdata = 7'h02;
    cyc();
    rd(2'd2, v); check("R6 chain flag set wins", 32'(v), 32'hF);
    check("R6 irq held", 32'(irq), 1);

    // Clear all flags, then a zero write to pending
    wr(2'd2, 7'h0F);
    check("R5 irq after flag clear", 32'(irq), 0);
    rd(2'd2, v); check("R5 flags cleared", 32'(v), 0);
    wr(2'd0, 7'h00);
    rd(2'd0, v); check("R5 zero write keeps pending", 32'(v), 32'h40);

    // Set wins on a pending bit
    evt_iconv = 1; conv_ch = 3'd6; wr_en = 1; addr = 2'd0; wdata = 7'h40;
    cyc();
    rd(2'd0, v); check("R6 pending ch6 set wins", 32'(v), 32'h40);

    // Mask write leaves pending alone and raises request
    wr(2'd1, 7'h7F);
    check("R7 irq with full channel mask", 32'(irq), 1);
    rd(2'd0, v); check("R10 pending unchanged by mask write", 32'(v), 32'h40);
    rd(2'd3, v); check("R8 event mask readback", 32'(v), 32'h02);

    // Reset in mid-run
    model_on = 0;
    rst = 1;
    @(posedge clk);
    #1;
    rst = 0;
    model_on = 1;
    check("R1 irq after second reset", 32'(irq), 0);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      check("R1 register after second reset", 32'(v), 0);
    end

    repeat (2) @(posedge clk);
    #1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule